// File: doc/BRIEF.md
# Set/Clear Register Parallel I/O Port Controller

This block controls a 32-pin parallel I/O port through a small memory-mapped register file on a simple synchronous bus. Every per-pin configuration bit lives in a bank that software can change only in two ways. A write to the bank's set address ORs the write data into the bank, and a write to its clear address removes the written ones. A third address reads the bank's current contents. Bits written as zero never disturb other pins.

Each pin has an owner. It is driven either by the port's own output data and output-enable registers or by one of two peripheral functions, selected per pin. An open-drain option turns any driven pin into a pull-low-only driver. Pull-up requests go straight out to the pads.

Pad inputs pass through a two-flop synchroniser and an optional per-pin glitch filter. The filtered level can always be read, whoever owns the pin. Any change of that level, rising or falling, is latched as pending. A masked OR of the pending bits drives the interrupt line. Reading the pending register returns its contents and empties it in the same access.

Top module: `pio_port_ctrl`

## Requirements
- R1: After synchronous reset every pin is owned by the port, output enable, output data, filter, open-drain, mask and peripheral select are all zero, pull-up is all ones, nothing is pending and `irq` is low.
- R2: The ownership bank uses set 0x00, clear 0x04 and status 0x08. A 1 gives the pin to the port's own output data (0x20/0x24/0x28) and output enable (0x10/0x14/0x18). A 0 gives it to a peripheral.
- R3: The peripheral select bank uses 0x70, which sets the bit and picks function B, and 0x74, which clears it and picks function A. Status is at 0x78, with 1 meaning B. A pin not owned by the port takes its output and enable from the selected peripheral.
- R4: Each bank is changed only by its set and clear writes; zero bits leave other pins unchanged, and the status address returns the bank. Pull-up is 0x30/0x34/0x38, filter 0x40/0x44/0x48, open-drain 0x50/0x54/0x58 and interrupt mask 0x60/0x64/0x68.
- R5: On a pin with open-drain enabled, `pad_out` is 0. `pad_oe` is high only when the selected source drives a 0 with its enable set.
- R6: Address 0x80 returns the synchronised, filtered pin levels whatever the ownership; `pin_in` carries the same levels.
- R7: Both rising and falling changes of a pin's filtered level set its bit in the pending register at 0x84.
- R8: With the filter enabled, a pin level must be seen equal on two consecutive synchronised samples before it is accepted. A one-cycle input pulse changes neither the level nor the pending bits, and a longer one is accepted.
- R9: A read of 0x84 returns the pending bits and clears them. A change detected in the same cycle as the read is not returned and stays pending for the next read.
- R10: `irq` is high exactly when some pending bit has its mask bit set.
- R11: Read data appears on `bus_rdata` in the cycle after the read. Unmapped or misaligned addresses read zero, and writes to status or read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pullup | output | 32 | Pad pull-up request |
| per_a_out | input | 32 | Peripheral A output values |
| per_a_oe | input | 32 | Peripheral A output enables |
| per_b_out | input | 32 | Peripheral B output values |
| per_b_oe | input | 32 | Peripheral B output enables |
| pin_in | output | 32 | Filtered pin levels to peripherals |
| irq | output | 1 | Masked change interrupt |

## Verification
Two functions can fall on the same clock edge: a read that empties the pending register, and a newly detected level change on a pin. The bench provokes this by changing a pad input exactly four edges before a pending read, counting the synchroniser, the level register and the change detector. It expects that read to return zero and the following read to return the new bit. The filter is judged the same way, by comparing a one-cycle pulse on a filtered pin with the same pulse on an unfiltered pin.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PIO_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_BANK = 8;
    localparam int BANK_IW  = $clog2(NUM_BANK);

    // configuration bank indices (address bits [7:4])
    localparam int BK_OWN  = 0;
    localparam int BK_OE   = 1;
    localparam int BK_OUT  = 2;
    localparam int BK_PULL = 3;
    localparam int BK_FILT = 4;
    localparam int BK_MD   = 5;
    localparam int BK_MASK = 6;
    localparam int BK_BSEL = 7;
    localparam int BK_IN   = 8;

    typedef enum logic [1:0] {
        ACC_SET  = 2'd0,
        ACC_CLR  = 2'd1,
        ACC_STAT = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    typedef struct packed {
        logic                cfg_hit;
        logic [BANK_IW-1:0]  idx;
        acc_e                acc;
        logic                lvl_hit;
        logic                pend_hit;
    } dec_t;

    function automatic logic bank_resets_high(int b);
        return (b == BK_OWN) || (b == BK_PULL);
    endfunction

    function automatic dec_t decode(logic [ADDR_W-1:0] a);
        dec_t d;
        d.cfg_hit  = 1'b0;
        d.idx      = a[4+BANK_IW-1:4];
        d.acc      = ACC_NONE;
        d.lvl_hit  = 1'b0;
        d.pend_hit = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (int'(a[7:4]) < NUM_BANK) begin
                if (a[3:2] != 2'd3) begin
                    d.cfg_hit = 1'b1;
                    d.acc     = acc_e'(a[3:2]);
                end
            end else if (int'(a[7:4]) == BK_IN) begin
                d.lvl_hit  = (a[3:2] == 2'd0);
                d.pend_hit = (a[3:2] == 2'd1);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_pkg::*;
#(
    parameter int W  = PIO_W,
    parameter int NB = NUM_BANK
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NB-1:0]        set_we,
    input  logic [NB-1:0]        clr_we,
    input  logic [W-1:0]         wdata,
    output logic [NB-1:0][W-1:0] q
);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [W-1:0] RST_VAL = bank_resets_high(b) ? '1 : '0;

        always_ff @(posedge clk) begin
            if (rst)            q[b] <= RST_VAL;
            else if (set_we[b]) q[b] <= q[b] | wdata;
            else if (clr_we[b]) q[b] <= q[b] & ~wdata;
        end

        assert_set_R4: assert property (@(posedge clk) disable iff (rst)
            set_we[b] |=> ((q[b] & $past(wdata)) == $past(wdata)));
        assert_clr_R4: assert property (@(posedge clk) disable iff (rst)
            clr_we[b] |=> ((q[b] & $past(wdata)) == '0));
        assert_keep_R4: assert property (@(posedge clk) disable iff (rst)
            (set_we[b] || clr_we[b]) |=>
                ((q[b] & ~$past(wdata)) == ($past(q[b]) & ~$past(wdata))));
        assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
            !(set_we[b] || clr_we[b]) |=> $stable(q[b]));
    end

endmodule

// File: rtl/pio_in_filter.sv
module pio_in_filter
    import pio_pkg::*;
#(
    parameter int W = PIO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] filt_en,
    output logic [W-1:0] lvl
);

    logic [W-1:0] meta, smp, smp_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta  <= '0;
            smp   <= '0;
            smp_d <= '0;
        end else begin
            meta  <= pad_in;
            smp   <= meta;
            smp_d <= smp;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                lvl[i] <= 1'b0;
            else if (!filt_en[i] || (smp[i] == smp_d[i]))
                lvl[i] <= smp[i];
        end
    end

    assert_filt_R8: assert property (@(posedge clk) disable iff (rst)
        (|filt_en) |=>
            (((lvl ^ $past(lvl)) & $past(filt_en) & ($past(smp) ^ $past(smp_d))) == '0));
    assert_track_R6: assert property (@(posedge clk) disable iff (rst)
        (|(lvl ^ smp)) |=> (((lvl ^ $past(lvl)) & ~$past(smp ^ lvl)) == '0));

endmodule

// File: rtl/pio_chg_irq.sv
module pio_chg_irq
    import pio_pkg::*;
#(
    parameter int W = PIO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] mask,
    input  logic         rd_clr,
    output logic [W-1:0] pending,
    output logic         irq
);

    logic [W-1:0] lvl_d;
    logic [W-1:0] chg;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= '0;
        else     lvl_d <= lvl;
    end

    assign chg = lvl ^ lvl_d;

    always_ff @(posedge clk) begin
        if (rst)         pending <= '0;
        else if (rd_clr) pending <= chg;
        else             pending <= pending | chg;
    end

    assign irq = |(pending & mask);

    assert_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (|(lvl ^ lvl_d)) |=>
            ((pending & ($past(lvl) ^ $past(lvl_d))) == ($past(lvl) ^ $past(lvl_d))));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> (($past(pending) & ~pending) == '0));
    assert_rdclr_R9: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> ((pending & ~($past(lvl) ^ $past(lvl_d))) == '0));
    assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
        ((pending & mask) == '0) |-> !irq);

endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
    import pio_pkg::*;
#(
    parameter int W = PIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_pullup,
    input  logic [W-1:0]      per_a_out,
    input  logic [W-1:0]      per_a_oe,
    input  logic [W-1:0]      per_b_out,
    input  logic [W-1:0]      per_b_oe,
    output logic [W-1:0]      pin_in,
    output logic              irq
);

    dec_t                      dec;
    logic [NUM_BANK-1:0]       set_we, clr_we;
    logic [NUM_BANK-1:0][W-1:0] cfg;
    logic [W-1:0]              lvl, pending, rd_val;
    logic                      rd_clr;
    logic [W-1:0]              src_out, src_oe;

    assign dec = decode(bus_addr);

    always_comb begin
        for (int b = 0; b < NUM_BANK; b++) begin
            set_we[b] = bus_sel && bus_wr && dec.cfg_hit &&
                        (int'(dec.idx) == b) && (dec.acc == ACC_SET);
            clr_we[b] = bus_sel && bus_wr && dec.cfg_hit &&
                        (int'(dec.idx) == b) && (dec.acc == ACC_CLR);
        end
    end

    pio_cfg_regs #(.W(W), .NB(NUM_BANK)) i_cfg (
        .clk    (clk),
        .rst    (rst),
        .set_we (set_we),
        .clr_we (clr_we),
        .wdata  (bus_wdata),
        .q      (cfg)
    );

    pio_in_filter #(.W(W)) i_filt (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .filt_en (cfg[BK_FILT]),
        .lvl     (lvl)
    );

    assign rd_clr = bus_sel && !bus_wr && dec.pend_hit;

    pio_chg_irq #(.W(W)) i_chg (
        .clk     (clk),
        .rst     (rst),
        .lvl     (lvl),
        .mask    (cfg[BK_MASK]),
        .rd_clr  (rd_clr),
        .pending (pending),
        .irq     (irq)
    );

    always_comb begin
        rd_val = '0;
        if (dec.cfg_hit && dec.acc == ACC_STAT) rd_val = cfg[dec.idx];
        else if (dec.lvl_hit)                   rd_val = lvl;
        else if (dec.pend_hit)                  rd_val = pending;
    end

    always_ff @(posedge clk) begin
        if (rst)                  bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_val;
    end

    // per-pin source mux: port registers or selected peripheral
    for (genvar i = 0; i < W; i++) begin : g_mux
        always_comb begin
            if (cfg[BK_OWN][i]) begin
                src_out[i] = cfg[BK_OUT][i];
                src_oe[i]  = cfg[BK_OE][i];
            end else if (cfg[BK_BSEL][i]) begin
                src_out[i] = per_b_out[i];
                src_oe[i]  = per_b_oe[i];
            end else begin
                src_out[i] = per_a_out[i];
                src_oe[i]  = per_a_oe[i];
            end
        end
    end

    assign pad_out    = src_out & ~cfg[BK_MD];
    assign pad_oe     = src_oe & ~(cfg[BK_MD] & src_out);
    assign pad_pullup = cfg[BK_PULL];
    assign pin_in     = lvl;

    assert_od_R5: assert property (@(posedge clk) disable iff (rst)
        ((cfg[BK_MD] & (pad_out | (pad_oe & src_out))) == '0));
    assert_unmapped_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !dec.cfg_hit && !dec.lvl_hit && !dec.pend_hit)
            |=> (bus_rdata == '0));
    assert_own_R2: assert property (@(posedge clk) disable iff (rst)
        ((cfg[BK_OWN] & ~cfg[BK_MD] & (pad_out ^ cfg[BK_OUT])) == '0));

endmodule

// File: tb/test_pio_port_ctrl.sv
module test_pio_port_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pullup, pin_in;
    logic [31:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0;
    logic        irq;

    int nchk = 0, nerr = 0;
    logic [31:0] m [8];
    logic [31:0] rv;

    always #10 clk = ~clk;

    pio_port_ctrl i_pio_port_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pullup(pad_pullup), .per_a_out(per_a_out), .per_a_oe(per_a_oe),
        .per_b_out(per_b_out), .per_b_oe(per_b_oe), .pin_in(pin_in), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    // write a bank with set (op=0) or clear (op=1) and track the model
    task automatic wrm(int b, int op, logic [31:0] d);
        wr(8'((b << 4) | (op << 2)), d);
        if (op == 0) m[b] = m[b] | d;
        else         m[b] = m[b] & ~d;
    endtask

    function automatic logic [31:0] exp_src_out();
        return (m[0] & m[2]) | (~m[0] & m[7] & per_b_out) | (~m[0] & ~m[7] & per_a_out);
    endfunction
    function automatic logic [31:0] exp_src_oe();
        return (m[0] & m[1]) | (~m[0] & m[7] & per_b_oe) | (~m[0] & ~m[7] & per_a_oe);
    endfunction

    task automatic chk_pads(string req);
        chk({req, " pad_out"}, pad_out, exp_src_out() & ~m[5]);
        chk({req, " pad_oe"}, pad_oe, exp_src_oe() & ~(m[5] & exp_src_out()));
        chk({req, " pad_pullup"}, pad_pullup, m[3]);
    endtask

    task automatic waitn(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_9bdf));
        for (int b = 0; b < 8; b++) m[b] = (b == 0 || b == 3) ? '1 : '0;
        waitn(5);
        rst = 1'b0;
        waitn(1);

        // R1 reset state
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_pullup", pad_pullup, '1);
        chk("R1 irq", {31'd0, irq}, '0);
        rd(8'h08, rv); chk("R1 own status", rv, '1);
        rd(8'h68, rv); chk("R1 mask status", rv, '0);
        rd(8'h78, rv); chk("R1 select status", rv, '0);
        rd(8'h84, rv); chk("R1 pending", rv, '0);

        // random set/clear traffic (R2 R3 R4 R5)
        for (int it = 0; it < 120; it++) begin
            int b, op;
            b  = int'($urandom % 8);
            op = int'($urandom % 2);
            per_a_out = $urandom; per_a_oe = $urandom;
            per_b_out = $urandom; per_b_oe = $urandom;
            wrm(b, op, $urandom);
            chk_pads("R2/R3/R5 random");
            rd(8'((b << 4) | 8), rv);
            chk("R4 status readback", rv, m[b]);
        end

        // directed R3: pin 0 to peripheral B
        wrm(5, 1, '1); wrm(0, 1, 32'h1); wrm(7, 0, 32'h1);
        per_b_out = 32'h1; per_b_oe = 32'h1; per_a_out = '0; per_a_oe = '0;
        waitn(1);
        chk("R3 pin0 from B", pad_out & 32'h1, 32'h1);
        wrm(7, 1, 32'h1);
        chk("R3 pin0 from A", pad_oe & 32'h1, 32'h0);
        // directed R5: open-drain on port-owned pin 1
        wrm(0, 0, 32'h2); wrm(1, 0, 32'h2); wrm(2, 0, 32'h2); wrm(5, 0, 32'h2);
        chk("R5 od release high", {pad_out[1], pad_oe[1]}, 32'h0);
        wrm(2, 1, 32'h2);
        chk("R5 od drive low", {pad_out[1], pad_oe[1]}, 32'h1);
        chk_pads("R5 all");

        // R11 decode corners
        rd(8'h0C, rv); chk("R11 unmapped 0x0C", rv, '0);
        rd(8'h90, rv); chk("R11 unmapped 0x90", rv, '0);
        rd(8'h09, rv); chk("R11 misaligned", rv, '0);
        wr(8'h18, '1);
        rd(8'h18, rv); chk("R11 status write ignored", rv, m[1]);

        // quiet inputs: no filter, no mask, no pending
        wrm(4, 1, '1); wrm(6, 1, '1);
        rd(8'h84, rv);

        // R6 / R7: level readable with pins given to peripherals
        wrm(0, 1, '1);
        pad_in = 32'hA5A5_0F0F;
        waitn(6);
        rd(8'h80, rv); chk("R6 level", rv, 32'hA5A5_0F0F);
        chk("R6 pin_in", pin_in, 32'hA5A5_0F0F);
        rd(8'h84, rv); chk("R7 rising pending", rv, 32'hA5A5_0F0F);
        pad_in = '0;
        waitn(6);
        rd(8'h84, rv); chk("R7 falling pending", rv, 32'hA5A5_0F0F);
        wrm(0, 0, '1);

        // R8 filter on pin 3, none on pin 4
        wrm(4, 0, 32'h8);
        pad_in = 32'h18; waitn(1); pad_in = '0;
        waitn(8);
        rd(8'h80, rv); chk("R8 filtered level", rv, '0);
        rd(8'h84, rv); chk("R8 pulse pending", rv, 32'h10);
        pad_in = 32'h8;
        waitn(8);
        rd(8'h80, rv); chk("R8 long pulse level", rv, 32'h8);
        rd(8'h84, rv); chk("R8 long pulse pending", rv, 32'h8);
        pad_in = '0; waitn(8); rd(8'h84, rv);

        // R10 masked interrupt
        wrm(6, 0, 32'h20);
        pad_in = 32'h40; waitn(8);
        chk("R10 unmasked change", {31'd0, irq}, '0);
        pad_in = 32'h60; waitn(8);
        chk("R10 masked change", {31'd0, irq}, 32'h1);
        rd(8'h84, rv); chk("R9 read pending", rv, 32'h60);
        chk("R10 irq after read", {31'd0, irq}, '0);
        rd(8'h84, rv); chk("R9 cleared", rv, '0);

        // R9 change lands on the read edge
        pad_in = 32'hE0;
        waitn(3);
        rd(8'h84, rv); chk("R9 same-cycle not returned", rv, '0);
        rd(8'h84, rv); chk("R9 same-cycle kept", rv, 32'h80);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule